// File: doc/BRIEF.md
# Watchdog Down-Counter with APB Register Access

This block is a watchdog timer that sits on an APB bus as a zero-wait-state slave. It keeps a programmable reload value and a live count. The count steps down by one on each cycle where the external tick-enable input is high and the block is enabled. The tick-enable input comes from a prescaler outside the block. When the count lands on zero, a sticky raw interrupt flag is set. The count then stays at zero until the next tick, and that tick loads it again from the reload value.

Software restarts the watchdog by writing any value to the clear register. In the same access this drops the flag and loads the count. A masked status and an interrupt pin follow the flag gated by the enable bit. A lock register guards every other writable register against stray writes. Only one fixed 32-bit key opens it.

Top module: `apb_wdog_timer`

## Requirements
- R1: After reset the count and the reload register read 0xFFFFFFFF. The control, raw status, masked status and lock registers read 0, and the interrupt pin is low.
- R2: Bit 0 of the control register enables the block. While this bit is 0, ticks do not change the count.
- R3: While enabled, each tick lowers a non-zero count by one. After N ticks from a load of L (with N < L) the count reads L-N and raw status reads 0.
- R4: The tick that brings the count to 0 sets raw status to 1. The count then reads 0 until the next tick.
- R5: A tick that finds the count at 0 loads it from the reload register. Raw status stays 1 until it is cleared.
- R6: A write of any data to the clear register sets raw status to 0 and loads the count from the reload register. Both changes are visible at the next access, with no tick needed.
- R7: A write to the reload register also loads the count with the written value.
- R8: Changing the spacing of ticks part-way through a count leaves the count value intact. The remaining ticks count at the new spacing.
- R9: Masked status (bit 0) and the interrupt pin equal raw status ANDed with the enable bit.
- R10: Writing the key 0xC0DE5AFE to the lock register unlocks the block, and writing any other value locks it. The lock register reads 1 when locked and 0 when unlocked. While locked, writes to the reload, control and clear registers are ignored.
- R11: The slave is always ready and never flags an error. Writes to the count, raw and masked status registers are ignored. Reads from undefined offsets return 0.
- R12: The byte offsets are: reload 0x000, count 0x004, control 0x008, clear 0x00C, raw status 0x010 (bit 0), masked status 0x014 (bit 0), lock 0xC00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| tick_en | input | 1 | One-cycle count enable from the prescaler |
| wdog_irq | output | 1 | Masked interrupt output |

## Verification
The bench builds the block with its default parameters: the 32-bit key 0xC0DE5AFE and an all-ones reset count. It loads small reload values (1 to 1000), so that reaching zero, the hold at zero and the reload wrap all happen within a few thousand ticks. The tick spacing is chosen by the bench and changed mid-count, which makes the rate-change case and several wrap periods reachable at random spacings.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int WDOG_AW = 12;
  localparam int WDOG_DW = 32;

  localparam logic [WDOG_AW-1:0] OFS_RELOAD = 12'h000;
  localparam logic [WDOG_AW-1:0] OFS_COUNT  = 12'h004;
  localparam logic [WDOG_AW-1:0] OFS_CTRL   = 12'h008;
  localparam logic [WDOG_AW-1:0] OFS_CLEAR  = 12'h00C;
  localparam logic [WDOG_AW-1:0] OFS_RAW    = 12'h010;
  localparam logic [WDOG_AW-1:0] OFS_MASKED = 12'h014;
  localparam logic [WDOG_AW-1:0] OFS_LOCK   = 12'hC00;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_RELOAD, SEL_COUNT, SEL_CTRL,
    SEL_CLEAR, SEL_RAW, SEL_MASKED, SEL_LOCK
  } wdog_sel_e;

  function automatic wdog_sel_e wdog_decode(input logic [WDOG_AW-1:0] a);
    case (a)
      OFS_RELOAD: return SEL_RELOAD;
      OFS_COUNT:  return SEL_COUNT;
      OFS_CTRL:   return SEL_CTRL;
      OFS_CLEAR:  return SEL_CLEAR;
      OFS_RAW:    return SEL_RAW;
      OFS_MASKED: return SEL_MASKED;
      OFS_LOCK:   return SEL_LOCK;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/wdog_apb_if.sv
module wdog_apb_if
  import wdog_pkg::*;
#(
  parameter int AW = WDOG_AW,
  parameter int DW = WDOG_DW
) (
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] reload,
  input  logic          en,
  input  logic          raw,
  input  logic          masked,
  input  logic          locked,
  output wdog_sel_e     sel,
  output logic          wr_go,
  output logic [DW-1:0] prdata
);
  localparam logic [DW-1:0] ZERO = '0;

  assign sel   = wdog_decode(paddr);
  assign wr_go = psel & penable & pwrite;

  always_comb begin
    prdata = ZERO;
    case (sel)
      SEL_RELOAD: prdata = reload;
      SEL_COUNT:  prdata = cnt;
      SEL_CTRL:   prdata = {ZERO[DW-1:1], en};
      SEL_RAW:    prdata = {ZERO[DW-1:1], raw};
      SEL_MASKED: prdata = {ZERO[DW-1:1], masked};
      SEL_LOCK:   prdata = {ZERO[DW-1:1], locked};
      default:    prdata = ZERO;
    endcase
  end
endmodule

// File: rtl/wdog_ctrl_regs.sv
module wdog_ctrl_regs
  import wdog_pkg::*;
#(
  parameter int          DW       = WDOG_DW,
  parameter logic [31:0] KEY      = 32'hC0DE_5AFE,
  parameter logic [31:0] RST_LOAD = 32'hFFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  wdog_sel_e     sel,
  input  logic [DW-1:0] wdata,
  input  logic          zero_evt,
  output logic [DW-1:0] reload_q,
  output logic          en_q,
  output logic          raw_q,
  output logic          locked_q,
  output logic          masked,
  output logic          ld,
  output logic [DW-1:0] ld_val,
  output logic          clr_evt
);
  logic wr_ok, reload_wr, ctrl_wr, lock_wr;

  // The lock register itself always accepts writes
  assign wr_ok     = wr_go & (~locked_q | (sel == SEL_LOCK));
  assign reload_wr = wr_ok & (sel == SEL_RELOAD);
  assign ctrl_wr   = wr_ok & (sel == SEL_CTRL);
  assign clr_evt   = wr_ok & (sel == SEL_CLEAR);
  assign lock_wr   = wr_ok & (sel == SEL_LOCK);

  assign ld     = reload_wr | clr_evt;
  assign ld_val = reload_wr ? wdata : reload_q;
  assign masked = raw_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RST_LOAD[DW-1:0];
      en_q     <= 1'b0;
      raw_q    <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      if (reload_wr) reload_q <= wdata;
      if (ctrl_wr)   en_q     <= wdata[0];
      if (lock_wr)   locked_q <= (wdata != KEY[DW-1:0]);
      if (clr_evt)       raw_q <= 1'b0;
      else if (zero_evt) raw_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
  parameter int          DW      = 32,
  parameter logic [31:0] RST_VAL = 32'hFFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  input  logic [DW-1:0] reload,
  output logic [DW-1:0] cnt,
  output logic          tick_act,
  output logic          zero_evt
);
  localparam logic [DW-1:0] ZERO = '0;
  localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};

  // Step rule: zero reloads, anything else counts down
  function automatic logic [DW-1:0] next_count(input logic [DW-1:0] c,
                                                input logic [DW-1:0] r);
    return (c == ZERO) ? r : c - ONE;
  endfunction

  logic [DW-1:0] cnt_nx;

  assign tick_act = en & tick;
  assign cnt_nx   = next_count(cnt, reload);
  assign zero_evt = tick_act & ~ld & (cnt_nx == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= RST_VAL[DW-1:0];
    else if (ld)       cnt <= ld_val;
    else if (tick_act) cnt <= cnt_nx;
  end
endmodule

// File: rtl/apb_wdog_timer.sv
module apb_wdog_timer
  import wdog_pkg::*;
#(
  parameter logic [31:0] LOCK_KEY   = 32'hC0DE_5AFE,
  parameter logic [31:0] RESET_LOAD = 32'hFFFF_FFFF
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [WDOG_AW-1:0] paddr,
  input  logic [WDOG_DW-1:0] pwdata,
  output logic [WDOG_DW-1:0] prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic               tick_en,
  output logic               wdog_irq
);
  wdog_sel_e          sel;
  logic               wr_go, en_q, raw_q, locked_q, masked;
  logic               ld, clr_evt, tick_act, zero_evt;
  logic [WDOG_DW-1:0] reload_q, ld_val, cnt;

  assign pready   = 1'b1;
  assign pslverr  = 1'b0;
  assign wdog_irq = masked;

  wdog_apb_if #(.AW(WDOG_AW), .DW(WDOG_DW)) u_if (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .cnt(cnt), .reload(reload_q), .en(en_q), .raw(raw_q),
    .masked(masked), .locked(locked_q),
    .sel(sel), .wr_go(wr_go), .prdata(prdata)
  );

  wdog_ctrl_regs #(.DW(WDOG_DW), .KEY(LOCK_KEY), .RST_LOAD(RESET_LOAD)) u_regs (
    .clk(pclk), .rst_n(presetn), .wr_go(wr_go), .sel(sel), .wdata(pwdata),
    .zero_evt(zero_evt), .reload_q(reload_q), .en_q(en_q), .raw_q(raw_q),
    .locked_q(locked_q), .masked(masked), .ld(ld), .ld_val(ld_val),
    .clr_evt(clr_evt)
  );

  wdog_down_counter #(.DW(WDOG_DW), .RST_VAL(RESET_LOAD)) u_cnt (
    .clk(pclk), .rst_n(presetn), .en(en_q), .tick(tick_en), .ld(ld),
    .ld_val(ld_val), .reload(reload_q), .cnt(cnt),
    .tick_act(tick_act), .zero_evt(zero_evt)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [WDOG_AW-1:0] paddr,
  input logic               pready,
  input logic               pslverr,
  input logic               irq,
  input logic               tick_act,
  input logic               zero_evt,
  input logic               ld,
  input logic               clr_evt,
  input logic [WDOG_DW-1:0] cnt,
  input logic [WDOG_DW-1:0] reload,
  input logic               en,
  input logic               raw,
  input logic               locked
);
  logic reload_try;
  assign reload_try = psel & penable & pwrite & (paddr == OFS_RELOAD);

  p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld) |=> $stable(cnt));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_act && !ld && cnt != '0) |=> (cnt == $past(cnt) - 1));

  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (raw && cnt == '0));

  p_wrap_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_act && !ld && cnt == '0) |=> (cnt == $past(reload) && raw));

  p_clear_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (!raw && cnt == $past(reload)));

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en && raw));

  p_locked_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && reload_try) |=> $stable(reload));

  p_bus_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pready && !pslverr));
endmodule

bind apb_wdog_timer wdog_checker u_chk (
  .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pready(pready), .pslverr(pslverr),
  .irq(wdog_irq), .tick_act(tick_act), .zero_evt(zero_evt), .ld(ld),
  .clr_evt(clr_evt), .cnt(cnt), .reload(reload_q), .en(en_q),
  .raw(raw_q), .locked(locked_q)
);

// File: tb/apb_wdog_timer_tb.sv
module apb_wdog_timer_tb;
  localparam logic [11:0] A_RLD = 12'h000, A_CNT = 12'h004, A_CTL = 12'h008,
                          A_CLR = 12'h00C, A_RAW = 12'h010, A_MSK = 12'h014,
                          A_LCK = 12'hC00, A_BAD = 12'h020;
  localparam logic [31:0] KEY = 32'hC0DE_5AFE;

  logic        pclk = 1'b0, presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, tick_en = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        pready, pslverr, wdog_irq;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #4 pclk = ~pclk;

  apb_wdog_timer u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .tick_en(tick_en), .wdog_irq(wdog_irq)
  );

  // Model: count after n ticks from a load of l, with wrap period l+1
  function automatic logic [31:0] exp_cnt(input int unsigned l, input int unsigned n);
    return l - (n % (l + 1));
  endfunction
  function automatic logic exp_raw(input int unsigned l, input int unsigned n);
    return (n > 0) && (n >= l);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1;
    #1 d = prdata;
    chk("R11 pready", {31'b0, pready}, 32'd1);
    chk("R11 pslverr", {31'b0, pslverr}, 32'd0);
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic run_ticks(input int n, input int div);
    for (int i = 0; i < n; i++) begin
      repeat (div - 1) @(negedge pclk);
      @(negedge pclk); tick_en = 1;
      @(negedge pclk); tick_en = 0;
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge pclk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int unsigned seed, l, n, dv;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge pclk);
    presetn = 1;

    // R1 reset state
    apb_rd(A_CNT, rd); chk("R1 count", rd, 32'hFFFF_FFFF);
    apb_rd(A_RLD, rd); chk("R1 reload", rd, 32'hFFFF_FFFF);
    apb_rd(A_CTL, rd); chk("R1 ctrl", rd, 0);
    apb_rd(A_RAW, rd); chk("R1 raw", rd, 0);
    apb_rd(A_MSK, rd); chk("R1 masked", rd, 0);
    apb_rd(A_LCK, rd); chk("R1 lock", rd, 0);
    chk("R1 irq", {31'b0, wdog_irq}, 0);
    apb_rd(A_BAD, rd); chk("R11 undefined", rd, 0);

    // R12 map, R7 load, R3 midpoint
    apb_wr(A_CTL, 1); apb_wr(A_RLD, 1000);
    apb_rd(A_CNT, rd); chk("R7 load sets count", rd, 1000);
    run_ticks(500, 4);
    apb_rd(A_CNT, rd); chk("R3 midpoint", rd, 500);
    apb_rd(A_RAW, rd); chk("R3 raw low", rd, 0);
    // R4 reach zero
    run_ticks(500, 4);
    apb_rd(A_CNT, rd); chk("R4 zero", rd, 0);
    apb_rd(A_RAW, rd); chk("R4 raw set", rd, 1);
    apb_rd(A_MSK, rd); chk("R9 masked", rd, 1);
    chk("R9 irq", {31'b0, wdog_irq}, 1);
    // R5 reload
    run_ticks(1, 4);
    apb_rd(A_CNT, rd); chk("R5 reloaded", rd, 1000);
    apb_rd(A_RAW, rd); chk("R5 raw sticky", rd, 1);
    // R6 clear
    run_ticks(500, 4);
    apb_rd(A_CNT, rd); chk("R6 pre-clear", rd, 500);
    apb_wr(A_CLR, 32'h0);
    apb_rd(A_CNT, rd); chk("R6 count reloaded", rd, 1000);
    apb_rd(A_RAW, rd); chk("R6 raw cleared", rd, 0);
    chk("R6 irq low", {31'b0, wdog_irq}, 0);
    // R8 rate change
    run_ticks(250, 4); run_ticks(250, 2);
    apb_rd(A_CNT, rd); chk("R8 rate change", rd, 500);

    // R9 masking and R2 disable
    apb_wr(A_RLD, 3); run_ticks(3, 2);
    apb_wr(A_CTL, 0);
    apb_rd(A_RAW, rd); chk("R9 raw kept", rd, 1);
    apb_rd(A_MSK, rd); chk("R9 masked off", rd, 0);
    chk("R9 irq off", {31'b0, wdog_irq}, 0);
    apb_wr(A_RLD, 7); run_ticks(5, 2);
    apb_rd(A_CNT, rd); chk("R2 disabled hold", rd, 7);

    // R11 read-only writes ignored
    apb_wr(A_CNT, 77); apb_rd(A_CNT, rd); chk("R11 count ro", rd, 7);
    apb_wr(A_RAW, 0);  apb_rd(A_RAW, rd); chk("R11 raw ro", rd, 1);

    // R10 lock
    apb_wr(A_LCK, 32'h1); apb_rd(A_LCK, rd); chk("R10 locked", rd, 1);
    apb_wr(A_RLD, 55); apb_rd(A_RLD, rd); chk("R10 reload blocked", rd, 7);
    apb_wr(A_CLR, 9);  apb_rd(A_RAW, rd); chk("R10 clear blocked", rd, 1);
    apb_wr(A_CTL, 1);  apb_rd(A_CTL, rd); chk("R10 ctrl blocked", rd, 0);
    apb_wr(A_LCK, KEY); apb_rd(A_LCK, rd); chk("R10 unlocked", rd, 0);
    apb_wr(A_CLR, 32'hDEAD_BEEF); apb_rd(A_RAW, rd); chk("R10 clear after unlock", rd, 0);

    // Random loads, tick counts and spacings
    apb_wr(A_CTL, 1);
    for (int k = 0; k < 20; k++) begin
      l  = 1 + ($urandom % 100);
      n  = $urandom % (3 * l);
      dv = 1 + ($urandom % 4);
      apb_wr(A_RLD, l); apb_wr(A_CLR, 0);
      run_ticks(n, dv);
      apb_rd(A_CNT, rd); chk("R3 R5 random count", rd, exp_cnt(l, n));
      apb_rd(A_RAW, rd); chk("R4 random raw", rd, {31'b0, exp_raw(l, n)});
      apb_wr(A_CLR, $urandom);
      apb_rd(A_CNT, rd); chk("R6 random clear", rd, l);
    end
    summary();
  end
endmodule